// File: doc/BRIEF.md
# Factorial Compute Unit

This block is a small memory-mapped calculator that produces the factorial of a 32-bit operand. Software writes the operand to the value register. The block then runs an iterative sequence of multiplies, one step per clock. When the sequence ends, the result overwrites the operand in that same register. Software learns that the result is ready in one of two ways. It can poll the busy flag in the status register. It can also set the completion-enable bit and wait for a one-cycle request on the interrupt output, which feeds an external interrupt aggregator as source bit 0.

The same register window also holds a fixed identification word and a scratch register that returns the inverse of whatever was last written to it. Requests use a simple valid/write/address/size interface. A read answers one cycle later with the register state as it stood before the request's clock edge. Only full 32-bit accesses have any effect. Narrower or wider reads return all ones, and writes of those sizes are discarded.

Top module: `fact_unit`

## Requirements
- R1: After a synchronous active-low reset, busy and completion-enable are clear, the value and scratch registers read 0, and irq_done is low.
- R2: A word read of offset 0x00 returns the constant 0x010000ED.
- R3: A word read of offset 0x04 returns the bitwise inverse of the last word written to offset 0x04.
- R4: A word write to offset 0x08 while idle stores the written operand and sets busy (status bit 0); while busy, offset 0x08 reads back the operand.
- R5: The result is the running product 1·n·(n−1)·…·1 truncated modulo 2^32 (operand 0 gives 1), and it replaces the operand at offset 0x08.
- R6: Busy stays set for exactly operand+1 clock cycles after the launching write's clock edge.
- R7: A word write to offset 0x08 while busy, including the cycle in which the run completes, is dropped and does not change the operand, the result or the run length.
- R8: A word write to the status register at offset 0x20 changes only bit 7 (completion-enable), which takes the written bit 7; all status bits other than 0 and 7 read 0.
- R9: When a run completes with bit 7 set, irq_done is high for exactly one cycle, namely the first cycle in which busy reads clear; the enable value that counts is the one held before the completion edge, so a status write on that same edge affects only later runs.
- R10: The req_size encoding is log2 of the byte count (0 byte, 1 half, 2 word, 3 double). Any access whose size is not 2 is a write with no effect, or a read that returns 0xFFFFFFFF.
- R11: Every read request produces rsp_valid in the next cycle, with data taken from the state before that edge; word reads of unmapped offsets return 0xFFFFFFFF and word writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte offset within the register window |
| req_size | input | 2 | log2 of the access size in bytes |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_data | output | DATA_W (32) | Read data |
| irq_done | output | 1 | One-cycle completion request to the interrupt aggregator (source bit 0) |

## Verification
Three things can land on the final clock edge of a run: completion, a status write that flips the completion-enable bit, and a new operand write. The bench launches an operand of known size. It then counts exactly operand+1 cycles so that a status write, or a second operand write, lands on the finishing edge. A behavioural cycle model, compared on every clock, judges the outcome. Directed checks add to it: the interrupt must follow the enable that was held before the edge, and the dropped operand must leave the first result untouched.

// File: rtl/fact_pkg.sv
// Package: shared constants for the factorial compute unit.
// Holds register offsets, status bit positions, the access-size code
// for a full word, and the identification constant.
package fact_pkg;

    localparam logic [7:0] OFF_ID   = 8'h00;
    localparam logic [7:0] OFF_SCR  = 8'h04;
    localparam logic [7:0] OFF_VAL  = 8'h08;
    localparam logic [7:0] OFF_STAT = 8'h20;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_IE_BIT   = 7;

    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic [31:0] ID_WORD = 32'h010000ED;

endpackage

// File: rtl/fact_engine.sv
// Module: fact_engine
// Iterative factorial sequencer. A start pulse loads the operand into the
// value register, seeds the running product with 1 and the down-counter
// with the operand. Each busy cycle multiplies the product by the counter
// and decrements it. When the counter is zero the product is written back
// to the value register and busy clears. done is high in that final cycle.
// Assumes: start is only asserted while busy is low.
module fact_engine #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] start_val,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] value
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic              busy_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] value_q;

    // Final cycle of a run: counter exhausted while busy.
    assign done  = busy_q && (cnt_q == '0);
    assign busy  = busy_q;
    assign value = value_q;

    // Load on start, one multiply-and-decrement step per cycle, write back on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            acc_q   <= '0;
            cnt_q   <= '0;
            value_q <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            acc_q   <= ONE;
            cnt_q   <= start_val;
            value_q <= start_val;
        end else if (done) begin
            busy_q  <= 1'b0;
            value_q <= acc_q;
        end else if (busy_q) begin
            acc_q <= acc_q * cnt_q;
            cnt_q <= cnt_q - ONE;
        end
    end

endmodule

// File: rtl/fact_regif.sv
// Module: fact_regif
// Register decode for the factorial unit. Holds the scratch register and
// the completion-enable bit, issues the engine start and forms the
// registered read response. Only full-word accesses take effect. Other
// sizes and unmapped offsets read as all ones.
// Assumes: one request per cycle; reads see state before the clock edge.
module fact_regif
    import fact_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] value,
    output logic              start,
    output logic [DATA_W-1:0] start_val,
    output logic              ie,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(OFF_ID);
    localparam logic [ADDR_W-1:0] A_SCR  = ADDR_W'(OFF_SCR);
    localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(OFF_VAL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

    logic              word_acc;
    logic              wr_ok;
    logic              rd_req;
    logic [DATA_W-1:0] scr_q;
    logic              ie_q;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rsp_data_q;
    logic [DATA_W-1:0] rd_word;

    assign word_acc  = (req_size == SZ_WORD);
    assign wr_ok     = req_valid && req_write && word_acc;
    assign rd_req    = req_valid && !req_write;
    assign start     = wr_ok && (req_addr == A_VAL) && !busy;
    assign start_val = req_wdata;
    assign ie        = ie_q;
    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;

    // Read multiplexer over the current register state.
    always_comb begin
        rd_word = '1;
        if (word_acc) begin
            case (req_addr)
                A_ID:    rd_word = DATA_W'(ID_WORD);
                A_SCR:   rd_word = scr_q;
                A_VAL:   rd_word = value;
                A_STAT: begin
                    rd_word                = '0;
                    rd_word[STAT_IE_BIT]   = ie_q;
                    rd_word[STAT_BUSY_BIT] = busy;
                end
                default: rd_word = '1;
            endcase
        end
    end

    // Scratch and enable register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scr_q <= '0;
            ie_q  <= 1'b0;
        end else if (wr_ok) begin
            if (req_addr == A_SCR) begin
                scr_q <= ~req_wdata;
            end
            if (req_addr == A_STAT) begin
                ie_q <= req_wdata[STAT_IE_BIT];
            end
        end
    end

    // Registered read response, data held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= rd_req;
            if (rd_req) begin
                rsp_data_q <= rd_word;
            end
        end
    end

endmodule

// File: rtl/fact_irq.sv
// Module: fact_irq
// Completion request generator. Registers a one-cycle pulse when the
// engine finishes while the enable bit (as held before that edge) is set.
// Assumes: done is high for a single cycle per run.
module fact_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic ie,
    output logic irq
);

    logic irq_q;

    assign irq = irq_q;

    // Pulse for one cycle after an enabled completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= done && ie;
        end
    end

endmodule

// File: rtl/fact_unit.sv
// Module: fact_unit (top)
// Memory-mapped factorial compute unit: register decode, iterative
// engine and completion request. Bus protocol adaptation and the
// interrupt aggregator sit outside this block.
// Assumes: synchronous active-low reset; one access per cycle.
module fact_unit #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              irq_done
);

    logic              eng_start;
    logic [DATA_W-1:0] eng_start_val;
    logic              eng_busy;
    logic              eng_done;
    logic [DATA_W-1:0] eng_value;
    logic              ie_bit;

    fact_regif #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) regif_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .busy      (eng_busy),
        .value     (eng_value),
        .start     (eng_start),
        .start_val (eng_start_val),
        .ie        (ie_bit),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    fact_engine #(
        .DATA_W (DATA_W)
    ) engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .start_val (eng_start_val),
        .busy      (eng_busy),
        .done      (eng_done),
        .value     (eng_value)
    );

    fact_irq irq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (eng_done),
        .ie    (ie_bit),
        .irq   (irq_done)
    );

endmodule

// File: rtl/fact_unit_chk.sv
// Module: fact_unit_chk
// Property checker bound into fact_unit. Observes the ports and the
// signals passed between the register decode, the engine and the
// request generator.
module fact_unit_chk
    import fact_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              irq_done,
    input logic              eng_busy,
    input logic              eng_done,
    input logic [DATA_W-1:0] eng_value,
    input logic              ie_bit
);

    logic wr_word;
    logic wr_val;
    logic wr_stat;

    assign wr_word = req_valid && req_write && (req_size == SZ_WORD);
    assign wr_val  = wr_word && (req_addr == ADDR_W'(OFF_VAL));
    assign wr_stat = wr_word && (req_addr == ADDR_W'(OFF_STAT));

    // R4: busy only rises after an operand write.
    a_r4_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_busy) |-> $past(wr_val));

    // R4: an idle operand write loads the operand and starts a run.
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_val && !eng_busy) |=> (eng_busy && eng_value == $past(req_wdata)));

    // R7: operand writes mid-run leave the value register untouched.
    a_r7_drop_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_val && eng_busy && !eng_done) |=> $stable(eng_value));

    // R8: a status write sets the enable to the written bit 7.
    a_r8_ie_follow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> (ie_bit == $past(req_wdata[STAT_IE_BIT])));

    // R9: the request follows a completion and busy is already clear.
    a_r9_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> (!eng_busy && $past(eng_done)));

    // R9: the request lasts a single cycle.
    a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);

    // R10: non-word reads answer with all ones.
    a_r10_bad_size_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size != SZ_WORD) |=> (rsp_valid && rsp_data == '1));

endmodule

bind fact_unit fact_unit_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .irq_done  (irq_done),
    .eng_busy  (eng_busy),
    .eng_done  (eng_done),
    .eng_value (eng_value),
    .ie_bit    (ie_bit)
);

// File: tb/fact_unit_tb_top.sv
// Bench: behavioural cycle model compared every clock, plus directed checks.
module fact_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = 2'd2;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              irq_done;

    fact_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .irq_done  (irq_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    int cycles   = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    function automatic logic [31:0] fact_of(input logic [31:0] n);
        logic [31:0] p = 32'd1;
        for (int k = 1; k <= int'(n); k++) p = p * 32'(k);
        return p;
    endfunction

    // Behavioural model state
    logic        m_busy = 0, m_ie = 0, m_rsp_v = 0, m_irq = 0;
    logic [31:0] m_cnt = 0, m_acc = 0, m_val = 0, m_scr = 0, m_rsp_d = 0;
    logic        p_busy, p_done;
    logic [31:0] p_rd;

    // Model update at every rising edge from the inputs held since the falling edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_ie = 0; m_rsp_v = 0; m_irq = 0;
            m_cnt = 0; m_acc = 0; m_val = 0; m_scr = 0; m_rsp_d = 0;
        end else begin
            p_busy = m_busy;
            p_done = m_busy && (m_cnt == 0);
            p_rd = 32'hFFFF_FFFF;
            if (req_size == 2'd2) begin
                case (req_addr)
                    8'h00: p_rd = 32'h0100_00ED;
                    8'h04: p_rd = m_scr;
                    8'h08: p_rd = m_val;
                    8'h20: p_rd = {24'd0, m_ie, 6'd0, m_busy};
                    default: p_rd = 32'hFFFF_FFFF;
                endcase
            end
            m_rsp_v = req_valid && !req_write;
            if (m_rsp_v) m_rsp_d = p_rd;
            m_irq = p_done && m_ie;
            if (p_done) begin
                m_val = m_acc; m_busy = 0;
            end else if (m_busy) begin
                m_acc = m_acc * m_cnt; m_cnt = m_cnt - 1;
            end
            if (req_valid && req_write && req_size == 2'd2) begin
                case (req_addr)
                    8'h04: m_scr = ~req_wdata;
                    8'h08: if (!p_busy) begin
                        m_val = req_wdata; m_acc = 1; m_cnt = req_wdata; m_busy = 1;
                    end
                    8'h20: m_ie = req_wdata[7];
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(irq_done == m_irq, "R9 irq_done vs model", 32'(irq_done), 32'(m_irq));
            chk(rsp_valid == m_rsp_v, "R11 rsp_valid vs model", 32'(rsp_valid), 32'(m_rsp_v));
            if (m_rsp_v) chk(rsp_data == m_rsp_d, "R11 rsp_data vs model", rsp_data, m_rsp_d);
        end
        if (cycles > WATCHDOG && !finished) begin
            chk(1'b0, "watchdog expired", 32'(cycles), 32'(WATCHDOG));
            report();
        end
    end

    // Tasks are entered and left at a falling edge.
    task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] d);
        req_valid = 1; req_write = 0; req_addr = a; req_size = sz; req_wdata = 0;
        @(negedge clk);
        d = rsp_data;
        req_valid = 0;
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        rd(a, sz, d);
        chk(d == exp, tag, d, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_expect(input logic [31:0] n, input string tag);
        wr(8'h08, 2'd2, n);
        idle(int'(n) + 3);
        rd_expect(8'h08, 2'd2, fact_of(n), tag);
    endtask

    initial begin
        logic [31:0] d;
        int busy_cnt;
        int irq_cnt;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(irq_done == 1'b0, "R1 irq after reset", 32'(irq_done), 0);
        rd_expect(8'h20, 2'd2, 32'h0, "R1 status after reset");
        rd_expect(8'h08, 2'd2, 32'h0, "R1 value after reset");
        rd_expect(8'h04, 2'd2, 32'h0, "R1 scratch after reset");
        // R2 identification
        rd_expect(8'h00, 2'd2, 32'h0100_00ED, "R2 id word");
        // R3 scratch inversion
        wr(8'h04, 2'd2, 32'h1234_5678);
        rd_expect(8'h04, 2'd2, 32'hEDCB_A987, "R3 scratch inverse");
        wr(8'h04, 2'd2, 32'h0);
        rd_expect(8'h04, 2'd2, 32'hFFFF_FFFF, "R3 scratch inverse of zero");
        // R10 size filtering
        rd_expect(8'h00, 2'd1, 32'hFFFF_FFFF, "R10 half read of id");
        wr(8'h04, 2'd0, 32'h0000_00AA);
        rd_expect(8'h04, 2'd2, 32'hFFFF_FFFF, "R10 byte write ignored");
        wr(8'h08, 2'd3, 32'd5);
        rd_expect(8'h20, 2'd2, 32'h0, "R10 dword operand write ignored");
        // R11 unmapped offset
        wr(8'h10, 2'd2, 32'h5555_5555);
        rd_expect(8'h10, 2'd2, 32'hFFFF_FFFF, "R11 unmapped read");
        // R8 status writes touch only bit 7
        wr(8'h20, 2'd2, 32'hFFFF_FF7F);
        rd_expect(8'h20, 2'd2, 32'h0, "R8 status other bits");
        wr(8'h20, 2'd2, 32'h0000_0080);
        rd_expect(8'h20, 2'd2, 32'h80, "R8 enable set");
        // R4 operand visible while busy
        wr(8'h08, 2'd2, 32'd4);
        rd_expect(8'h08, 2'd2, 32'd4, "R4 operand while busy");
        rd_expect(8'h20, 2'd2, 32'h81, "R4 busy set");
        idle(6);
        rd_expect(8'h08, 2'd2, 32'd24, "R5 result of 4");
        // R6 busy length, R9 single pulse
        wr(8'h08, 2'd2, 32'd5);
        busy_cnt = 0; irq_cnt = 0;
        for (int i = 0; i < 20; i++) begin
            rd(8'h20, 2'd2, d);
            if (irq_done) irq_cnt++;
            if (d[0]) busy_cnt++;
            else break;
        end
        chk(busy_cnt == 6, "R6 busy cycles for operand 5", 32'(busy_cnt), 32'd6);
        chk(irq_cnt == 1, "R9 one pulse per run", 32'(irq_cnt), 32'd1);
        rd_expect(8'h08, 2'd2, 32'd120, "R5 result of 5");
        // R5 boundaries: zero, one, wrap
        run_expect(32'd0, "R5 operand zero");
        run_expect(32'd1, "R5 operand one");
        run_expect(32'd13, "R5 wrap modulo 2^32");
        // R7 operand write mid-run dropped
        wr(8'h08, 2'd2, 32'd6);
        idle(2);
        wr(8'h08, 2'd2, 32'd3);
        idle(6);
        rd_expect(8'h08, 2'd2, 32'd720, "R7 mid-run write dropped");
        // R7 operand write on the completion edge dropped
        wr(8'h08, 2'd2, 32'd2);
        idle(2);
        wr(8'h08, 2'd2, 32'd7);
        rd_expect(8'h08, 2'd2, 32'd2, "R7 completion-edge write dropped");
        rd_expect(8'h20, 2'd2, 32'h80, "R7 no new run started");
        // R9 enable written on completion edge: old value counts
        wr(8'h20, 2'd2, 32'h0);
        wr(8'h08, 2'd2, 32'd3);
        idle(3);
        wr(8'h20, 2'd2, 32'h80);
        chk(irq_done == 1'b0, "R9 enable set at completion edge", 32'(irq_done), 0);
        wr(8'h08, 2'd2, 32'd3);
        idle(3);
        wr(8'h20, 2'd2, 32'h0);
        chk(irq_done == 1'b1, "R9 enable cleared at completion edge", 32'(irq_done), 1);
        idle(1);
        chk(irq_done == 1'b0, "R9 pulse ends", 32'(irq_done), 0);
        // R9 disabled completion gives no request
        wr(8'h08, 2'd2, 32'd2);
        irq_cnt = 0;
        for (int i = 0; i < 6; i++) begin
            idle(1);
            if (irq_done) irq_cnt++;
        end
        chk(irq_cnt == 0, "R9 no request when disabled", 32'(irq_cnt), 0);
        idle(2);
        report();
    end

endmodule